// File: doc/BRIEF.md
# DMA Source Address Update Unit

This block holds the source address of one DMA channel and moves it after every completed transfer. A two-bit mode field picks a held, rising or falling address. The step is one for byte transfers and two for word transfers. When the source is an external device served in single-address mode, the address is held whatever the mode field says.

An optional repeat area confines the address to an aligned window of 2^N bytes. Only the low N bits move and the upper bits keep their value. When the low bits wrap, the block can stop the channel and set a sticky interrupt flag. In block transfer mode the stop waits for the end of the current block. Software resumes the channel by setting the active bit again. The address is not reloaded, so transfer continues from the address reached at the stop.

Top module: `dma_srcaddr_unit`

## Requirements
- R1: After reset, src_addr is 0, active is 0, irq_flag is 0 and irq is 0.
- R2: A load pulse puts start_addr on src_addr at the next edge. An act_set pulse makes active 1 at the next edge.
- R3: With mode 2'b00 or 2'b01, a completed transfer leaves src_addr unchanged.
- R4: With mode 2'b10 and no repeat area, a completed transfer adds 1 (word_xfer=0) or 2 (word_xfer=1), modulo 2^16.
- R5: With mode 2'b11, a completed transfer subtracts 1 for a byte or 2 for a word. Inside a repeat area the low bits wrap downward.
- R6: While dack_single is 1, a completed transfer leaves src_addr unchanged in every mode.
- R7: While active is 0, xfer_done has no effect on src_addr.
- R8: With rpt_en=1 and rpt_size=N (1 to 15), only address bits N-1..0 change on a transfer. They wrap modulo 2^N and bits 15..N stay fixed. rpt_size=0 means no repeat area.
- R9: Outside block mode, a wrap of the repeat window with rpt_ie=1 does three things at the same edge as the address update: it sets irq_flag, clears active, and stores the wrapped address.
- R10: A wrap with rpt_ie=0, or rpt_ie=1 with no repeat area, leaves active at 1 and irq_flag at 0.
- R11: In block mode (block_mode=1), a qualifying wrap keeps the channel active. The stop and the flag come at the first edge where block_end is 1, which may be the wrap edge itself.
- R12: irq is 1 exactly when irq_flag is 1 and irq_en is 1.
- R13: Setting act_set after a stop makes active 1 again with src_addr unchanged. The next transfer steps from that address.
- R14: irq_flag stays 1 until a flag_clr pulse. When a stop and flag_clr fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Load start_addr into the address register |
| start_addr | input | 16 | Start address |
| act_set | input | 1 | Set the channel active bit |
| flag_clr | input | 1 | Clear the interrupt flag |
| xfer_done | input | 1 | One transfer has completed |
| block_mode | input | 1 | Block transfer mode selected |
| block_end | input | 1 | Current block-size transfer ends this cycle |
| mode | input | 2 | Update mode: 0X hold, 10 up, 11 down |
| word_xfer | input | 1 | 1 = word transfer (step 2), 0 = byte (step 1) |
| dack_single | input | 1 | Source is an external device in single-address mode |
| rpt_en | input | 1 | Repeat area configured |
| rpt_size | input | 4 | Repeat window size exponent N |
| rpt_ie | input | 1 | Stop and flag on repeat window wrap |
| irq_en | input | 1 | Channel interrupt enable |
| src_addr | output | 16 | Current source address |
| active | output | 1 | Channel active bit |
| irq_flag | output | 1 | Sticky repeat interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:
- A word step that crosses the window boundary from an odd or even low value. A design that tests only for an all-ones low field would miss this overflow.
- A downward wrap from zero. Getting the borrow wrong would disturb the upper address bits.
- Block mode with the wrap in the middle of a block and with the wrap on the closing transfer. An eager design stops too early; a late one loses the flag.
- Resuming after a stop. A design that reloads or re-steps the address shows a jump there.
- A flag clear in the same cycle as a new stop. A design that gives the clear priority would drop the interrupt.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;
endpackage

// File: rtl/dsa_rst_sync.sv
module dsa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/dsa_step.sv
module dsa_step
  import dsa_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    mode,
  input  logic          word_xfer,
  input  logic          dack_single,
  output dir_e          dir,
  output logic [AW-1:0] delta
);
  always_comb begin
    dir = DIR_HOLD;
    if (!dack_single) begin
      case (mode)
        2'b10:   dir = DIR_UP;
        2'b11:   dir = DIR_DOWN;
        default: dir = DIR_HOLD;
      endcase
    end
    delta = word_xfer ? AW'(2) : AW'(1);
  end
endmodule

// File: rtl/dsa_wrap.sv
module dsa_wrap
  import dsa_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RSW = 4
) (
  input  logic [AW-1:0]  cur_addr,
  input  dir_e           dir,
  input  logic [AW-1:0]  delta,
  input  logic           rpt_on,
  input  logic [RSW-1:0] rpt_size,
  output logic [AW-1:0]  nxt_addr,
  output logic           wrap_ovf
);
  logic [AW-1:0] win_mask;
  logic [AW-1:0] low;
  logic [AW:0]   sum_up;
  logic [AW:0]   sum_dn;
  logic [AW-1:0] raw;
  logic          ovf_up;
  logic          ovf_dn;

  always_comb begin
    win_mask = rpt_on ? ((AW'(1) << rpt_size) - AW'(1)) : '1;
    low      = cur_addr & win_mask;
    sum_up   = {1'b0, low} + {1'b0, delta};
    sum_dn   = {1'b0, low} - {1'b0, delta};
    ovf_up   = sum_up[AW] || ((sum_up[AW-1:0] & ~win_mask) != '0);
    ovf_dn   = (low < delta);
    case (dir)
      DIR_UP:   raw = sum_up[AW-1:0];
      DIR_DOWN: raw = sum_dn[AW-1:0];
      default:  raw = low;
    endcase
    nxt_addr = (cur_addr & ~win_mask) | (raw & win_mask);
    case (dir)
      DIR_UP:   wrap_ovf = rpt_on && ovf_up;
      DIR_DOWN: wrap_ovf = rpt_on && ovf_dn;
      default:  wrap_ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsa_ctrl.sv
module dsa_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          act_set,
  input  logic          flag_clr,
  input  logic          xfer_done,
  input  logic          block_mode,
  input  logic          block_end,
  input  logic          rpt_ie,
  input  logic [AW-1:0] nxt_addr,
  input  logic          wrap_ovf,
  output logic [AW-1:0] addr_q,
  output logic          active_q,
  output logic          flag_q
);
  logic          pend_q;
  logic [AW-1:0] addr_d;
  logic          active_d;
  logic          flag_d;
  logic          pend_d;
  logic          addr_en;
  logic          adv;
  logic          ovf_hit;
  logic          arm;
  logic          stop;

  always_comb begin
    adv      = active_q && xfer_done;
    ovf_hit  = adv && wrap_ovf && rpt_ie;
    arm      = pend_q || ovf_hit;
    stop     = active_q && arm && (!block_mode || block_end);
    addr_en  = load || adv;
    addr_d   = load ? start_addr : nxt_addr;
    active_d = stop ? 1'b0 : (act_set ? 1'b1 : active_q);
    flag_d   = stop ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    if (load || stop) pend_d = 1'b0;
    else if (ovf_hit) pend_d = 1'b1;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      active_q <= 1'b0;
      flag_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      active_q <= active_d;
      flag_q   <= flag_d;
      pend_q   <= pend_d;
    end
  end

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !load) |=> $stable(addr_q));

  assert_flag_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_stop_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> flag_q);

  assert_block_defer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && block_mode && !block_end) |=> active_q);

  assert_resume_in_place_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active_q) && !$past(load)) |-> $stable(addr_q));
endmodule

// File: rtl/dma_srcaddr_unit.sv
module dma_srcaddr_unit
  import dsa_pkg::*;
#(
  parameter int AW          = 16,
  parameter int RSW         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  start_addr,
  input  logic           act_set,
  input  logic           flag_clr,
  input  logic           xfer_done,
  input  logic           block_mode,
  input  logic           block_end,
  input  logic [1:0]     mode,
  input  logic           word_xfer,
  input  logic           dack_single,
  input  logic           rpt_en,
  input  logic [RSW-1:0] rpt_size,
  input  logic           rpt_ie,
  input  logic           irq_en,
  output logic [AW-1:0]  src_addr,
  output logic           active,
  output logic           irq_flag,
  output logic           irq
);
  logic          rst_sync_n;
  dir_e          dir;
  logic [AW-1:0] delta;
  logic [AW-1:0] nxt_addr;
  logic          wrap_ovf;
  logic          rpt_on;
  logic [AW-1:0] hi_mask;

  assign rpt_on  = rpt_en && (rpt_size != '0);
  assign hi_mask = ~((AW'(1) << rpt_size) - AW'(1));

  dsa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dsa_step #(.AW(AW)) u_step (
    .mode        (mode),
    .word_xfer   (word_xfer),
    .dack_single (dack_single),
    .dir         (dir),
    .delta       (delta)
  );

  dsa_wrap #(.AW(AW), .RSW(RSW)) u_wrap (
    .cur_addr (src_addr),
    .dir      (dir),
    .delta    (delta),
    .rpt_on   (rpt_on),
    .rpt_size (rpt_size),
    .nxt_addr (nxt_addr),
    .wrap_ovf (wrap_ovf)
  );

  dsa_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (load),
    .start_addr (start_addr),
    .act_set    (act_set),
    .flag_clr   (flag_clr),
    .xfer_done  (xfer_done),
    .block_mode (block_mode),
    .block_end  (block_end),
    .rpt_ie     (rpt_ie),
    .nxt_addr   (nxt_addr),
    .wrap_ovf   (wrap_ovf),
    .addr_q     (src_addr),
    .active_q   (active),
    .flag_q     (irq_flag)
  );

  assign irq = irq_flag && irq_en;

  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && xfer_done && !load && !mode[1]) |=> $stable(src_addr));

  assert_dack_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && xfer_done && !load && dack_single) |=> $stable(src_addr));

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && xfer_done && !load && rpt_on) |=>
      (((src_addr ^ $past(src_addr)) & $past(hi_mask)) == '0));
endmodule

// File: tb/dma_srcaddr_unit_tb.sv
`timescale 1ns/1ps
module dma_srcaddr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 0, act_set = 0, flag_clr = 0, xfer_done = 0;
  logic        block_mode = 0, block_end = 0, word_xfer = 0, dack_single = 0;
  logic        rpt_en = 0, rpt_ie = 0, irq_en = 0;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  rpt_size = 4'd0;
  logic [15:0] start_addr = 16'h0;
  logic [15:0] src_addr;
  logic        active, irq_flag, irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_addr = 16'h0;
  logic m_act = 0, m_flag = 0, m_pend = 0;
  string atag = "R1";

  always #4 clk = ~clk;

  dma_srcaddr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .act_set(act_set), .flag_clr(flag_clr), .xfer_done(xfer_done),
    .block_mode(block_mode), .block_end(block_end), .mode(mode),
    .word_xfer(word_xfer), .dack_single(dack_single), .rpt_en(rpt_en),
    .rpt_size(rpt_size), .rpt_ie(rpt_ie), .irq_en(irq_en),
    .src_addr(src_addr), .active(active), .irq_flag(irq_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_step();
    int a, lo, nl, win, d;
    logic ovf, adv, hit, arm, stp;
    logic [15:0] na;
    a = int'(m_addr);
    d = word_xfer ? 2 : 1;
    ovf = 1'b0;
    na = m_addr;
    if (!dack_single && mode[1]) begin
      if (rpt_en && rpt_size != 0) begin
        win = 1 << rpt_size;
        lo = a % win;
        nl = mode[0] ? lo - d : lo + d;
        ovf = (nl < 0) || (nl >= win);
        nl = (nl + win) % win;
        na = 16'(a - lo + nl);
      end else begin
        na = 16'((mode[0] ? a - d + 65536 : a + d) % 65536);
      end
    end
    if (load) atag = "R2";
    else if (!m_act || !xfer_done) atag = "R7";
    else if (dack_single) atag = "R6";
    else if (rpt_en && rpt_size != 0) atag = "R8";
    else if (!mode[1]) atag = "R3";
    else if (!mode[0]) atag = "R4";
    else atag = "R5";
    adv = m_act && xfer_done;
    hit = adv && ovf && rpt_ie;
    arm = m_pend || hit;
    stp = m_act && arm && (!block_mode || block_end);
    if (load) m_addr = start_addr;
    else if (adv) m_addr = na;
    m_pend = (load || stp) ? 1'b0 : (hit ? 1'b1 : m_pend);
    m_flag = stp ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    m_act  = stp ? 1'b0 : (act_set ? 1'b1 : m_act);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(atag, 32'(src_addr), 32'(m_addr));
    chk(block_mode ? "R11 active" : "R9 active", 32'(active), 32'(m_act));
    chk(block_mode ? "R11 flag" : "R9 flag", 32'(irq_flag), 32'(m_flag));
    chk("R12 irq", 32'(irq), 32'(m_flag && irq_en));
    load = 0; act_set = 0; flag_clr = 0; xfer_done = 0; block_end = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 addr", 32'(src_addr), 32'h0);
    chk("R1 active", 32'(active), 32'h0);
    chk("R1 flag", 32'(irq_flag), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    load = 1; start_addr = 16'h1234; tick();
    chk("R2 load", 32'(src_addr), 32'h1234);
    xfer_done = 1; mode = 2'b10; tick();
    chk("R7 idle", 32'(src_addr), 32'h1234);
    act_set = 1; tick();
    chk("R2 act", 32'(active), 32'h1);
    mode = 2'b00; xfer_done = 1; tick();
    chk("R3 mode00", 32'(src_addr), 32'h1234);
    mode = 2'b01; xfer_done = 1; tick();
    chk("R3 mode01", 32'(src_addr), 32'h1234);
    mode = 2'b10; rpt_ie = 1; irq_en = 1; xfer_done = 1; tick();
    chk("R4 byte", 32'(src_addr), 32'h1235);
    chk("R10 no area", 32'(irq_flag), 32'h0);
    word_xfer = 1; xfer_done = 1; tick();
    chk("R4 word", 32'(src_addr), 32'h1237);
    mode = 2'b11; word_xfer = 0; xfer_done = 1; tick();
    chk("R5 byte", 32'(src_addr), 32'h1236);
    word_xfer = 1; xfer_done = 1; tick();
    chk("R5 word", 32'(src_addr), 32'h1234);
    dack_single = 1; mode = 2'b10; xfer_done = 1; tick();
    chk("R6 dack", 32'(src_addr), 32'h1234);
    dack_single = 0; word_xfer = 0;
    load = 1; start_addr = 16'hFFFF; tick();
    xfer_done = 1; tick();
    chk("R4 rollover", 32'(src_addr), 32'h0000);

    rpt_en = 1; rpt_size = 4'd4; rpt_ie = 0;
    load = 1; start_addr = 16'h12FE; tick();
    xfer_done = 1; tick();
    xfer_done = 1; tick();
    chk("R8 wrap", 32'(src_addr), 32'h12F0);
    chk("R10 active", 32'(active), 32'h1);
    chk("R10 flag", 32'(irq_flag), 32'h0);
    rpt_ie = 1; load = 1; start_addr = 16'h12FF; tick();
    xfer_done = 1; tick();
    chk("R9 addr", 32'(src_addr), 32'h12F0);
    chk("R9 active", 32'(active), 32'h0);
    chk("R9 flag", 32'(irq_flag), 32'h1);
    chk("R12 irq on", 32'(irq), 32'h1);
    irq_en = 0; tick();
    chk("R12 irq off", 32'(irq), 32'h0);
    irq_en = 1; xfer_done = 1; tick();
    chk("R7 stopped", 32'(src_addr), 32'h12F0);
    chk("R14 sticky", 32'(irq_flag), 32'h1);
    act_set = 1; tick();
    chk("R13 active", 32'(active), 32'h1);
    chk("R13 addr", 32'(src_addr), 32'h12F0);
    xfer_done = 1; tick();
    chk("R13 step", 32'(src_addr), 32'h12F1);
    flag_clr = 1; tick();
    chk("R14 clear", 32'(irq_flag), 32'h0);
    load = 1; start_addr = 16'h1200; mode = 2'b11; word_xfer = 1; tick();
    xfer_done = 1; flag_clr = 1; tick();
    chk("R5 wrap down", 32'(src_addr), 32'h120E);
    chk("R14 set wins", 32'(irq_flag), 32'h1);
    flag_clr = 1; tick();
    act_set = 1; tick();
    block_mode = 1; mode = 2'b10; word_xfer = 0;
    load = 1; start_addr = 16'h12FF; tick();
    xfer_done = 1; tick();
    chk("R11 addr", 32'(src_addr), 32'h12F0);
    chk("R11 deferred", 32'(active), 32'h1);
    chk("R11 no flag", 32'(irq_flag), 32'h0);
    xfer_done = 1; tick();
    chk("R11 still", 32'(active), 32'h1);
    xfer_done = 1; block_end = 1; tick();
    chk("R11 end addr", 32'(src_addr), 32'h12F2);
    chk("R11 end stop", 32'(active), 32'h0);
    chk("R11 end flag", 32'(irq_flag), 32'h1);
    block_mode = 0; flag_clr = 1; act_set = 1; tick();

    for (int i = 0; i < 4000; i++) begin
      load = ($urandom % 20) == 0;
      start_addr = 16'($urandom);
      act_set = ($urandom % 8) == 0;
      flag_clr = ($urandom % 10) == 0;
      xfer_done = ($urandom % 2) == 0;
      block_end = ($urandom % 6) == 0;
      if (($urandom % 50) == 0) block_mode = ~block_mode;
      if (($urandom % 10) == 0) mode = 2'($urandom);
      word_xfer = 1'($urandom);
      dack_single = ($urandom % 10) == 0;
      if (($urandom % 30) == 0) rpt_en = ~rpt_en;
      if (($urandom % 40) == 0) rpt_size = 4'($urandom % 7);
      if (($urandom % 25) == 0) rpt_ie = ~rpt_ie;
      if (($urandom % 15) == 0) irq_en = ~irq_en;
      tick();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule